// File: doc/BRIEF.md
# Page-Local Non-Unit Stride Detector

This block watches cache misses that no unit-stride tracker has claimed. It looks for a fixed byte distance between successive misses that land in the same page. It keeps a small table with one entry per recently seen page. Each entry records three things: the last line address observed in that page, the byte difference to the line before it, and a count of how many times in a row that difference has repeated.

A miss on a page that has no entry takes a slot chosen by a wrapping round-robin pointer. A miss on a page that has an entry compares its new difference with the stored one. Once the same nonzero difference has been confirmed more times than the training threshold, the block requests a new prefetch stream. The request carries a signed stride measured in cache lines, and the entry is freed at the same time.

Misses arrive on a valid/ready input. Allocation requests leave on a valid/ready output. An allocation request that has not been taken holds its value, and while it waits the input ready is low. In every other cycle the input ready is high. A miss is accepted on a rising clock edge where both `miss_valid` and `miss_ready` are high.

Top module: `page_stride_detector`

## Requirements
- R1: After reset, `hit_o` and `alloc_valid` are 0, `miss_ready` is 1, and the table holds no entries, so the first miss to any page does not hit.
- R2: An accepted miss whose page matches no entry gives `hit_o` = 0. The miss is written at the round-robin slot with difference 0 and count 0, and the pointer then advances, wrapping after ENTRIES slots. With 8 entries, a ninth new page evicts the oldest one, and no two entries ever hold the same page.
- R3: An accepted miss whose page matches an entry raises `hit_o` for exactly one cycle, in the cycle after acceptance.
- R4: On a match, the difference is the new line address minus the stored one, in bytes. If it is nonzero and equal to the stored difference, the count increments. If it is nonzero and different, the count returns to 0. If it is zero, the count is left unchanged. Whenever the entry is not freed, the new line and the new difference, including a zero difference, are stored.
- R5: When an increment makes the count strictly greater than TRAIN_THRESH (default 4), the block raises `alloc_valid` in the next cycle. `alloc_stride` then equals the difference divided by the line size, as a two's-complement number of lines. The entry is freed, so the next miss to that page does not hit.
- R6: A zero difference never produces an allocation, no matter how often it repeats.
- R7: While `alloc_valid` = 1 and `alloc_ready` = 0, `alloc_stride` and `alloc_valid` hold their values and `miss_ready` is 0. Once the request is taken, `alloc_valid` drops in the next cycle, unless that same edge accepted a miss that allocates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is offered |
| miss_ready | output | 1 | Block can take a miss this cycle |
| miss_addr | input | ADDR_W | Byte address of the miss |
| hit_o | output | 1 | One-cycle pulse: last accepted miss matched a page entry |
| alloc_valid | output | 1 | Stream allocation request pending |
| alloc_ready | input | 1 | Consumer takes the allocation request |
| alloc_stride | output | PAGE_LG-LINE_LG+1 | Signed stride in cache lines |

## Verification
The assertions take for granted that the consumer's `alloc_ready` and the producer's `miss_valid` and `miss_addr` are free of X once reset is released. They also take for granted that a miss is acted on only on an edge where `miss_ready` was high. The bench drives these inputs only on the falling edge. It never treats an offered miss as taken until it has seen `miss_ready` high, and it holds `alloc_ready` low for several cycles so that the hold and stall rules are exercised under real back-pressure.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic [1:0] {
    ENT_KEEP  = 2'd0,
    ENT_LOAD  = 2'd1,
    ENT_CLEAR = 2'd2
  } ent_act_e;
endpackage

// File: rtl/psd_entry.sv
module psd_entry
  import psd_pkg::*;
#(
  parameter int LINE_W  = 26,
  parameter int DELTA_W = 13,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ent_act_e           act,
  input  logic [LINE_W-1:0]  ld_line,
  input  logic [DELTA_W-1:0] ld_delta,
  input  logic [CNT_W-1:0]   ld_cnt,
  output logic               vld,
  output logic [LINE_W-1:0]  line,
  output logic [DELTA_W-1:0] delta,
  output logic [CNT_W-1:0]   cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      line  <= '0;
      delta <= '0;
      cnt   <= '0;
    end else begin
      case (act)
        ENT_LOAD: begin
          vld   <= 1'b1;
          line  <= ld_line;
          delta <= ld_delta;
          cnt   <= ld_cnt;
        end
        ENT_CLEAR: begin
          vld   <= 1'b0;
          line  <= '0;
          delta <= '0;
          cnt   <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/psd_first.sv
module psd_first #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/page_stride_detector.sv
module page_stride_detector
  import psd_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LINE_LG      = 6,
  parameter int PAGE_LG      = 12,
  parameter int ENTRIES      = 8,
  parameter int TRAIN_THRESH = 4,
  localparam int STRIDE_W    = PAGE_LG - LINE_LG + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss_valid,
  output logic                       miss_ready,
  input  logic [ADDR_W-1:0]          miss_addr,
  output logic                       hit_o,
  output logic                       alloc_valid,
  input  logic                       alloc_ready,
  output logic signed [STRIDE_W-1:0] alloc_stride
);
  localparam int LINE_W  = ADDR_W - LINE_LG;
  localparam int PL      = PAGE_LG - LINE_LG;
  localparam int DELTA_W = PAGE_LG + 1;
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W   = $clog2(TRAIN_THRESH + 2);

  logic [LINE_W-1:0]  e_line  [ENTRIES];
  logic [DELTA_W-1:0] e_delta [ENTRIES];
  logic [CNT_W-1:0]   e_cnt   [ENTRIES];
  logic [ENTRIES-1:0] e_vld;
  logic [ENTRIES-1:0] match;
  ent_act_e           e_act   [ENTRIES];

  logic               fire, found, do_alloc, nz, same;
  logic [IW-1:0]      hit_idx, rr_ptr;
  logic [LINE_W-1:0]  new_line, sel_line;
  logic [DELTA_W-1:0] sel_delta, delta, ld_delta;
  logic [CNT_W-1:0]   sel_cnt, cnt_inc, cnt_nxt, ld_cnt;
  logic signed [STRIDE_W-1:0] line_diff;
  logic signed [DELTA_W-1:0]  delta_s;

  assign miss_ready = !alloc_valid || alloc_ready;
  assign fire       = miss_valid && miss_ready;
  assign new_line   = miss_addr[ADDR_W-1:LINE_LG];

  // page compare per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign match[g] = e_vld[g] && (e_line[g][LINE_W-1:PL] == new_line[LINE_W-1:PL]);

    always_comb begin
      e_act[g] = ENT_KEEP;
      if (fire && found && hit_idx == IW'(g))
        e_act[g] = do_alloc ? ENT_CLEAR : ENT_LOAD;
      else if (fire && !found && rr_ptr == IW'(g))
        e_act[g] = ENT_LOAD;
    end

    psd_entry #(.LINE_W(LINE_W), .DELTA_W(DELTA_W), .CNT_W(CNT_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .act(e_act[g]),
      .ld_line(new_line), .ld_delta(ld_delta), .ld_cnt(ld_cnt),
      .vld(e_vld[g]), .line(e_line[g]), .delta(e_delta[g]), .cnt(e_cnt[g])
    );
  end

  psd_first #(.N(ENTRIES)) u_first (.req(match), .found(found), .idx(hit_idx));

  assign sel_line  = e_line[hit_idx];
  assign sel_delta = e_delta[hit_idx];
  assign sel_cnt   = e_cnt[hit_idx];

  // byte difference inside one page, signed
  assign line_diff = $signed({1'b0, new_line[PL-1:0]}) - $signed({1'b0, sel_line[PL-1:0]});
  assign delta     = {line_diff, {LINE_LG{1'b0}}};
  assign delta_s   = $signed(delta);
  assign nz        = (delta != '0);
  assign same      = (delta == sel_delta);
  assign cnt_inc   = sel_cnt + 1'b1;

  always_comb begin
    if (!nz)       cnt_nxt = sel_cnt;
    else if (same) cnt_nxt = cnt_inc;
    else           cnt_nxt = '0;
  end

  assign do_alloc = fire && found && nz && same && (cnt_inc > CNT_W'(TRAIN_THRESH));
  assign ld_delta = found ? delta : '0;
  assign ld_cnt   = found ? cnt_nxt : '0;

  logic signed [DELTA_W-1:0] stride_full;
  assign stride_full = delta_s >>> LINE_LG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr       <= '0;
      hit_o        <= 1'b0;
      alloc_valid  <= 1'b0;
      alloc_stride <= '0;
    end else begin
      hit_o <= fire && found;
      if (fire && !found)
        rr_ptr <= (rr_ptr == IW'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      if (do_alloc) begin
        alloc_valid  <= 1'b1;
        alloc_stride <= stride_full[STRIDE_W-1:0];
      end else if (alloc_ready) begin
        alloc_valid  <= 1'b0;
      end
    end
  end

  // R2: a page lives in at most one slot
  assert_single_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $onehot0(match));
  // R3: hit pulse only follows an accepted miss
  assert_hit_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(fire));
  // R5: a fresh allocation is accompanied by a hit on the same miss
  assert_alloc_with_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alloc_valid) |-> hit_o);
  // R6: zero stride is never requested
  assert_no_zero_stride_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> alloc_stride != '0);
  // R7: a stalled request holds
  assert_alloc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> (alloc_valid && $stable(alloc_stride)));
  // R7: nothing is taken while stalled
  assert_stall_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> !hit_o);
endmodule

// File: tb/page_stride_detector_tb.sv
module page_stride_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        alloc_ready = 1'b1;
  logic        miss_ready, hit_o, alloc_valid;
  logic signed [6:0] alloc_stride;

  always #5 clk = ~clk;

  page_stride_detector dut_i (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .hit_o(hit_o), .alloc_valid(alloc_valid),
    .alloc_ready(alloc_ready), .alloc_stride(alloc_stride)
  );

  int tests = 0, fails = 0, cycles = 0, alloc_seen = 0;
  string tag = "R1";

  // behavioural reference
  bit     m_v [8];
  longint m_line [8];
  longint m_dl [8];
  int     m_cnt [8];
  int     m_rr = 0;
  bit     x_hit = 0, x_av = 0;
  int     x_stride = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_v[i]) begin m_v[i] = 0; m_line[i] = 0; m_dl[i] = 0; m_cnt[i] = 0; end
      m_rr = 0; x_hit = 0; x_av = 0; x_stride = 0;
    end else begin
      bit acc;
      acc = miss_valid && (!x_av || alloc_ready);
      x_hit = 0;
      if (x_av && alloc_ready) x_av = 0;
      if (acc) begin
        longint ln, d;
        int k;
        ln = longint'(miss_addr) >> 6;
        k = -1;
        for (int i = 7; i >= 0; i--)
          if (m_v[i] && (m_line[i] >> 6) == (ln >> 6)) k = i;
        if (k >= 0) begin
          x_hit = 1;
          d = (ln - m_line[k]) * 64;
          if (d != 0) m_cnt[k] = (d == m_dl[k]) ? m_cnt[k] + 1 : 0;
          if (d != 0 && m_cnt[k] > 4) begin
            x_av = 1; x_stride = int'(d / 64);
            m_v[k] = 0; m_line[k] = 0; m_dl[k] = 0; m_cnt[k] = 0;
          end else begin
            m_line[k] = ln; m_dl[k] = d;
          end
        end else begin
          m_v[m_rr] = 1; m_line[m_rr] = ln; m_dl[m_rr] = 0; m_cnt[m_rr] = 0;
          m_rr = (m_rr + 1) % 8;
        end
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      cycles++;
      chk(hit_o == x_hit, {tag, "/R3 hit"}, hit_o, x_hit);
      chk(alloc_valid == x_av, {tag, "/R5 alloc_valid"}, alloc_valid, x_av);
      if (x_av) chk(int'(alloc_stride) == x_stride, {tag, "/R5 stride"}, alloc_stride, x_stride);
      chk(miss_ready == (!x_av || alloc_ready), {tag, "/R7 ready"}, miss_ready, (!x_av || alloc_ready));
      if (alloc_valid && alloc_ready) alloc_seen++;
    end
  end

  task automatic send(input logic [31:0] a);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a;
    #1;
    while (!miss_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(hit_o == 0 && alloc_valid == 0, "R1 reset outputs", {hit_o, alloc_valid}, 0);
    chk(miss_ready == 1, "R1 reset ready", miss_ready, 1);
    send(32'h0000_5040);
    #3; chk(hit_o == 0, "R1 empty table no hit", hit_o, 0);

    // R5 positive stride of 3 lines
    tag = "R5"; alloc_seen = 0;
    for (int i = 0; i < 7; i++) send(32'h0001_0000 + i * 192);
    repeat (2) @(negedge clk);
    chk(alloc_seen == 1, "R5 one alloc after training", alloc_seen, 1);
    send(32'h0001_0800);
    #3; chk(hit_o == 0, "R5 entry freed", hit_o, 0);

    // R5 negative stride of 2 lines
    alloc_seen = 0;
    for (int i = 0; i < 7; i++) send(32'h0002_0F80 - i * 128);
    repeat (2) @(negedge clk);
    chk(alloc_seen == 1, "R5 negative alloc", alloc_seen, 1);

    // R4 difference change resets count
    tag = "R4"; alloc_seen = 0;
    send(32'h0003_0000); send(32'h0003_0100); send(32'h0003_0200); send(32'h0003_0300);
    send(32'h0003_0340); send(32'h0003_0380); send(32'h0003_03C0);
    send(32'h0003_0400); send(32'h0003_0440);
    chk(alloc_seen == 0, "R4 reset count blocks alloc", alloc_seen, 0);
    send(32'h0003_0480);
    repeat (2) @(negedge clk);
    chk(alloc_seen == 1, "R4 alloc after retrain", alloc_seen, 1);

    // R4 zero delta keeps count
    alloc_seen = 0;
    for (int i = 0; i < 5; i++) send(32'h0004_0000 + i * 256);
    send(32'h0004_0400 + 4);
    send(32'h0004_0500);
    repeat (2) @(negedge clk);
    chk(alloc_seen == 0, "R4 zero delta then change", alloc_seen, 0);

    // R6 repeated zero difference
    tag = "R6"; alloc_seen = 0;
    for (int i = 0; i < 10; i++) send(32'h0005_0080 + (i % 2) * 8);
    repeat (2) @(negedge clk);
    chk(alloc_seen == 0, "R6 zero never allocates", alloc_seen, 0);

    // R2 round-robin eviction
    tag = "R2";
    for (int i = 0; i < 9; i++) send(32'h0010_0000 + i * 4096);
    send(32'h0010_0040);
    #3; chk(hit_o == 0, "R2 oldest evicted", hit_o, 0);
    send(32'h0010_8040);
    #3; chk(hit_o == 1, "R2 newest kept", hit_o, 1);

    // R7 back-pressure
    tag = "R7";
    @(negedge clk); alloc_ready = 1'b0;
    for (int i = 0; i < 7; i++) send(32'h0020_0000 + i * 320);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = 32'h0030_0000;
    repeat (4) @(negedge clk);
    #1; chk(alloc_valid == 1 && miss_ready == 0, "R7 stalled", {alloc_valid, miss_ready}, 2);
    chk(int'(alloc_stride) == 5, "R7 stride held", alloc_stride, 5);
    @(negedge clk); alloc_ready = 1'b1;
    @(negedge clk); miss_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1; chk(alloc_valid == 0, "R7 drained", alloc_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule